// File: doc/BRIEF.md
# Write-Posting Store Buffer

This block sits between a write-through data cache and the external data bus master. A CPU store is written into a small first-in first-out queue and acknowledged to the CPU in the same cycle, so the CPU does not wait for memory. The queue then writes its entries to the bus one at a time, oldest first, with the same address, data and byte selects the CPU gave.

Loads are not buffered. A CPU load is held back until every queued store has been written, and only then is it driven onto the bus. This keeps the memory order strict without any decoding of address regions. An error response to a queued store is dropped, because the CPU has already moved on. An error response to a load is returned to the CPU.

A build parameter removes the queue altogether. Requests and responses then pass straight through, and stores wait for the bus like loads do.

Top module: `store_post_buffer`

## Requirements
- R1: With fewer than 2**LOG_DEPTH stores pending, a CPU store (`cpu_req`=1, `cpu_we`=1) gets `cpu_ack`=1 in the same cycle. `cpu_err` stays 0.
- R2: The queue holds 2**LOG_DEPTH entries, with LOG_DEPTH set to 2 or 3. While that many stores are pending, a new store is not acknowledged. It is acknowledged only once at least one entry has been written out.
- R3: Pending stores go out on the bus in the order they were accepted, with `bus_we`=1 and the same address, data and byte selects. Each one is held unchanged on the bus until `bus_ack` or `bus_err` arrives.
- R4: A CPU load (`cpu_we`=0) never appears on the bus while any store is pending. Once the queue is empty, the load is passed to the bus and its `bus_ack` and `bus_rdata` return to the CPU.
- R5: A `bus_err` on a queued store is never shown on `cpu_err`. The entry is retired as if it had been acknowledged.
- R6: A `bus_err` on a load is returned on `cpu_err` in the same cycle.
- R7: After reset the queue is empty and `bus_req` is 0 until a request arrives.
- R8: With BYPASS=1, `bus_req`, `bus_we`, address, data and byte selects follow the CPU port directly. `cpu_ack` and `cpu_err` follow `bus_ack` and `bus_err` for both loads and stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | CPU request, held until acknowledged |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | CPU address |
| cpu_wdata | input | 32 | Store data |
| cpu_sel | input | 4 | Byte selects |
| cpu_ack | output | 1 | Request completed |
| cpu_err | output | 1 | Load (or bypassed store) failed |
| cpu_rdata | output | 32 | Load data |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | Bus write enable |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_sel | output | 4 | Bus byte selects |
| bus_ack | input | 1 | Bus completion |
| bus_err | input | 1 | Bus error completion |
| bus_rdata | input | 32 | Bus read data |

## Verification
The assertions assume the following about the inputs:
- The CPU keeps a request and its fields steady until it is acknowledged.
- The bus answers only while `bus_req` is high, and never raises `bus_ack` and `bus_err` together.

The stimulus stays within these rules in two ways:
- Requests are issued only through tasks that hold every field until `cpu_ack`.
- The bus responder counts cycles only while a request is present, and answers with exactly one of ack or err, depending on the address.

// File: rtl/store_post_buffer.sv
module store_post_buffer #(
  parameter int LOG_DEPTH = 2,
  parameter bit BYPASS    = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  input  logic [3:0]  cpu_sel,
  output logic        cpu_ack,
  output logic        cpu_err,
  output logic [31:0] cpu_rdata,
  output logic        bus_req,
  output logic        bus_we,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  output logic [3:0]  bus_sel,
  input  logic        bus_ack,
  input  logic        bus_err,
  input  logic [31:0] bus_rdata
);
  localparam int DEPTH = 1 << LOG_DEPTH;

  assign cpu_rdata = bus_rdata;

  if (BYPASS) begin : g_through
    assign bus_req   = cpu_req;
    assign bus_we    = cpu_we;
    assign bus_addr  = cpu_addr;
    assign bus_wdata = cpu_wdata;
    assign bus_sel   = cpu_sel;
    assign cpu_ack   = bus_ack;
    assign cpu_err   = bus_err;
  end else begin : g_queue
    logic [LOG_DEPTH:0]   wp, rp;
    logic [LOG_DEPTH-1:0] wi, ri;
    logic [31:0] addr_q [DEPTH];
    logic [31:0] data_q [DEPTH];
    logic [3:0]  sel_q  [DEPTH];
    logic empty, full, push, pop, load_go;

    assign wi      = wp[LOG_DEPTH-1:0];
    assign ri      = rp[LOG_DEPTH-1:0];
    assign empty   = (wp == rp);
    assign full    = (wp[LOG_DEPTH] != rp[LOG_DEPTH]) && (wi == ri);
    assign push    = cpu_req && cpu_we && !full;
    assign pop     = !empty && (bus_ack || bus_err);
    assign load_go = cpu_req && !cpu_we && empty;

    assign bus_req   = !empty || load_go;
    assign bus_we    = !empty;
    assign bus_addr  = empty ? cpu_addr : addr_q[ri];
    assign bus_sel   = empty ? cpu_sel  : sel_q[ri];
    assign bus_wdata = data_q[ri];

    assign cpu_ack = push || (load_go && bus_ack);
    assign cpu_err = load_go && bus_err;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (push) wp <= wp + 1'b1;
        if (pop)  rp <= rp + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (push) begin
        addr_q[wi] <= cpu_addr;
        data_q[wi] <= cpu_wdata;
        sel_q[wi]  <= cpu_sel;
      end
    end
  end
endmodule

// File: rtl/store_post_buffer_chk.sv
module store_post_buffer_chk #(
  parameter int LOG_DEPTH = 2,
  parameter bit BYPASS    = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic        cpu_we,
  input logic        cpu_ack,
  input logic        cpu_err,
  input logic        bus_req,
  input logic        bus_we,
  input logic [31:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [3:0]  bus_sel,
  input logic        bus_ack,
  input logic        bus_err
);
  localparam int DEPTH = 1 << LOG_DEPTH;

  if (BYPASS) begin : g_through_chk
    a_r8_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack == bus_ack) && (cpu_err == bus_err) && (bus_req == cpu_req));
  end else begin : g_queue_chk
    logic [LOG_DEPTH+1:0] occ;
    logic in_s, out_s;
    assign in_s  = cpu_req && cpu_we && cpu_ack;
    assign out_s = bus_req && bus_we && (bus_ack || bus_err);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= '0;
      else occ <= occ + (LOG_DEPTH+2)'(in_s) - (LOG_DEPTH+2)'(out_s);
    end

    a_r1_store_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we && occ < DEPTH) |-> (cpu_ack && !cpu_err));
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      in_s |-> (occ < DEPTH));
    a_r3_head_held: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && !bus_ack && !bus_err) |=>
      (bus_req && bus_we && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_sel)));
    a_r4_load_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we) |-> (occ == 0));
    a_r5_store_err_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we) |-> !cpu_err);
    a_r6_load_err: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_we && bus_req && !bus_we && bus_err) |-> cpu_err);
    a_r7_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == 0) |-> !(bus_req && bus_we));
  end
endmodule

bind store_post_buffer store_post_buffer_chk #(.LOG_DEPTH(LOG_DEPTH), .BYPASS(BYPASS)) u_chk (.*);

// File: tb/store_post_buffer_test.sv
`timescale 1ns/1ps
module store_post_buffer_test;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic [3:0] cpu_sel = 0;
  logic cpu_ack, cpu_err, bus_req, bus_we, bus_ack, bus_err;
  logic [31:0] cpu_rdata, bus_addr, bus_wdata, bus_rdata;
  logic [3:0] bus_sel;

  store_post_buffer #(.LOG_DEPTH(2), .BYPASS(1'b0)) uut (.*);

  logic b_req = 0, b_we = 0, b_back = 0, b_berr = 0;
  logic b_ack, b_err, b_breq, b_bwe;
  logic [31:0] b_rdata, b_baddr, b_bwdata;
  logic [3:0] b_bsel;
  store_post_buffer #(.LOG_DEPTH(2), .BYPASS(1'b1)) uut_bypass (
    .clk(clk), .rst_n(rst_n), .cpu_req(b_req), .cpu_we(b_we), .cpu_addr(32'h40),
    .cpu_wdata(32'h1234), .cpu_sel(4'hF), .cpu_ack(b_ack), .cpu_err(b_err),
    .cpu_rdata(b_rdata), .bus_req(b_breq), .bus_we(b_bwe), .bus_addr(b_baddr),
    .bus_wdata(b_bwdata), .bus_sel(b_bsel), .bus_ack(b_back), .bus_err(b_berr),
    .bus_rdata(32'h0));

  int lat = 0, cnt = 0;
  logic [31:0] mem [16];
  logic [31:0] exp_mem [16];
  logic [31:0] q_addr [512];
  logic [31:0] q_data [512];
  logic [3:0]  q_sel  [512];
  int issued = 0, logged = 0, checks = 0, fails = 0;
  logic resp;

  assign resp      = bus_req && (cnt == lat);
  assign bus_err   = resp && (bus_addr[31:28] == 4'hE);
  assign bus_ack   = resp && (bus_addr[31:28] != 4'hE);
  assign bus_rdata = mem[bus_addr[5:2]];

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] s);
    for (int b = 0; b < 4; b++) if (s[b]) o[8*b +: 8] = n[8*b +: 8];
    return o;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (bus_req && !resp) cnt <= cnt + 1; else cnt <= 0;
    if (bus_req && !bus_we) chk(issued == logged, "R4 load on bus with stores pending", issued - logged, 0);
    if (bus_req && bus_we && resp) begin
      chk(bus_addr == q_addr[logged] && bus_wdata == q_data[logged] && bus_sel == q_sel[logged],
          "R3 drain order/content", bus_addr, q_addr[logged]);
      if (bus_ack) mem[bus_addr[5:2]] <= merge(mem[bus_addr[5:2]], bus_wdata, bus_sel);
      logged <= logged + 1;
    end
  end

  task automatic store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s, output int waits);
    waits = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d; cpu_sel = s;
    forever begin
      #5;
      if (cpu_ack) break;
      @(negedge clk);
      waits++;
    end
    chk(issued - logged < 4, "R2 store acked while full", issued - logged, 3);
    chk(!cpu_err, "R5 store error visible", cpu_err, 0);
    q_addr[issued] = a; q_data[issued] = d; q_sel[issued] = s;
    if (a[31:28] != 4'hE) exp_mem[a[5:2]] = merge(exp_mem[a[5:2]], d, s);
    issued++;
    @(posedge clk); #1;
    cpu_req = 0;
  endtask

  task automatic load(input logic [31:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = a; cpu_sel = 4'hF;
    forever begin
      #5;
      if (cpu_ack || cpu_err) break;
      @(negedge clk);
    end
    d = cpu_rdata; e = cpu_err;
    chk(issued == logged, "R4 load completed before drain", logged, issued);
    @(posedge clk); #1;
    cpu_req = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int w;
    logic [31:0] d;
    logic e;
    for (int i = 0; i < 16; i++) begin mem[i] = 32'h0; exp_mem[i] = 32'h0; end
    #5;
    chk(!bus_req && !cpu_ack, "R7 reset idle", {bus_req, cpu_ack}, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #5;
    chk(!bus_req, "R7 idle after reset", bus_req, 0);

    for (int l = 0; l < 4; l++) begin
      lat = l;
      for (int n = 1; n <= 8; n++) begin
        for (int i = 0; i < n; i++) begin
          store(((i * 5 + l + n) % 16) << 2, 32'hA000_0000 + l * 4096 + n * 256 + i,
                4'((i + n) % 15 + 1), w);
          if (i < 4) chk(w == 0, "R1 immediate store ack", w, 0);
        end
        for (int k = 0; k < 16; k += 5) begin
          load(k << 2, d, e);
          chk(d == exp_mem[k] && !e, "R4 load data after drain", d, exp_mem[k]);
        end
      end
    end

    lat = 12;
    for (int i = 0; i < 4; i++) begin
      store(i << 2, 32'h5500 + i, 4'hF, w);
      chk(w == 0, "R1 fill without wait", w, 0);
    end
    store(32'h20, 32'h77, 4'h3, w);
    chk(w > 0, "R2 fifth store stalls when full", w, 1);
    load(32'h20, d, e);
    chk(d == exp_mem[8], "R3 last store visible", d, exp_mem[8]);

    lat = 1;
    store(32'hE000_0010, 32'hDEAD, 4'hF, w);
    store(32'h0000_0004, 32'hBEEF, 4'hF, w);
    load(32'h4, d, e);
    chk(d == exp_mem[1] && !e, "R5 masked error entry retired", d, exp_mem[1]);
    load(32'hE000_0000, d, e);
    chk(e, "R6 load error reported", e, 1);

    @(negedge clk);
    b_req = 1; b_we = 1; #5;
    chk(b_breq && b_bwe && !b_ack && b_baddr == 32'h40, "R8 bypass store waits for bus", b_ack, 0);
    b_back = 1; #1;
    chk(b_ack && !b_err, "R8 bypass ack follows bus", b_ack, 1);
    b_back = 0; b_berr = 1; #1;
    chk(b_err, "R8 bypass store error reported", b_err, 1);
    @(negedge clk);
    b_berr = 0; b_req = 0; #1;
    chk(!b_breq, "R8 bypass request drops", b_breq, 0);

    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule